// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synchronous static RAM for on-chip use. It has a small, parameterised depth and a 36-bit word made of four 9-bit byte lanes. Every synchronous input is captured in a register on the rising clock edge. The access itself happens one edge later, and read data leaves through an output register. A burst begins when either of two address strobes loads an external address. One strobe is meant for a processor and the other for a cache controller. A 2-bit counter then produces the next three word addresses, and it moves only while the step input is asserted. An order-select input chooses a linear or an interleaved sequence.

Writes take their data in the same cycle as the write controls. Several lanes can be written at once through per-lane selects qualified by a lane-write enable, or all four lanes through a global write input, which overrides the lane controls. Three chip enables must all be active for a strobe to select the device. A strobe that arrives while the device is not fully selected deselects it. The output drive then stays on for one more cycle and turns off on the cycle after that, which allows back-to-back banks to hand over the bus cleanly.

Top module: `burst_sram`

## Requirements
- R1: Inputs are registered, and read data and `dq_oe` change on the second rising edge after the read strobe is applied. The sample taken one cycle after the strobe still shows the state from before the strobe.
- R2: `proc_strobe_n` low with all three `chip_en_n` bits low starts a read burst at `addr_in`. It is ignored while `chip_en_n[0]` is high, and any burst already in progress continues unchanged.
- R3: `ctrl_strobe_n` low with all chip enables low starts a burst at `addr_in`. That beat is a write when write controls are active in the same cycle, and a read otherwise.
- R4: During a burst, a cycle with `step_n` low advances the 2-bit burst count before the access. A cycle with `step_n` high repeats the current address.
- R5: With `order_sel` low, the low two address bits of beat k are (loaded low bits + k) mod 4. The upper bits stay fixed.
- R6: With `order_sel` high, the low two address bits of beat k are the loaded low bits XOR k.
- R7: With `all_wr_n` high and `lane_wr_en_n` low, a write stores exactly the lanes whose `lane_sel_n` bit is low. Bit i selects data bits [9i+8:9i], and the other lanes keep their contents.
- R8: With `all_wr_n` low, a write stores all four lanes whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R9: A strobe taken while any `chip_en_n` bit is high performs no access and ends the burst. Memory contents are unchanged.
- R10: After a deselect is registered, `dq_oe` keeps its value for one more cycle and is low on the cycle after that.
- R11: A registered write cycle drives `dq_oe` low on the following edge.
- R12: While reset is asserted and after it is released, `dq_oe` is low until a read has been registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External word address loaded by a strobe |
| proc_strobe_n | input | 1 | Processor burst-start strobe, active low |
| ctrl_strobe_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 linear, 1 interleaved burst order |
| chip_en_n | input | 3 | Chip enables, all active low; bit 0 is primary |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| din | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Output drive enable |

## Verification
The assertions decode intent straight from the pins, so they assume that the inputs hold steady through each clock edge and that `order_sel` does not change inside a burst. The bench drives every input on the falling edge and keeps the order fixed for the length of each burst. The write-mask checks assume that any write beat that is not global has `lane_wr_en_n` low. The bench raises `lane_wr_en_n` only together with `all_wr_n` low, or while no write is requested.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } sram_op_e;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    step_n,
  input  logic                    order_sel,
  input  logic [2:0]              chip_en_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] din,
  output sram_op_e                op,
  output logic                    load,
  output logic                    step,
  output logic [ADDR_W-1:0]       ld_addr,
  output logic                    order,
  output logic [LANES-1:0]        wr_mask,
  output logic [LANES*LANE_W-1:0] wr_data
);
  localparam int DATA_W = LANES * LANE_W;

  // captured inputs
  logic [ADDR_W-1:0] addr_q;
  logic              proc_q, ctrl_q, step_q, order_q, gw_q, lwe_q;
  logic [2:0]        ce_q;
  logic [LANES-1:0]  lsel_q;
  logic [DATA_W-1:0] din_q;
  logic              busy_q, busy_d;
  logic              sel_all, proc_go, wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      proc_q  <= 1'b1;
      ctrl_q  <= 1'b1;
      step_q  <= 1'b1;
      order_q <= 1'b0;
      gw_q    <= 1'b1;
      lwe_q   <= 1'b1;
      ce_q    <= '1;
      lsel_q  <= '1;
      din_q   <= '0;
    end else begin
      addr_q  <= addr_in;
      proc_q  <= proc_strobe_n;
      ctrl_q  <= ctrl_strobe_n;
      step_q  <= step_n;
      order_q <= order_sel;
      gw_q    <= all_wr_n;
      lwe_q   <= lane_wr_en_n;
      ce_q    <= chip_en_n;
      lsel_q  <= lane_sel_n;
      din_q   <= din;
    end
  end

  always_comb begin
    sel_all = (ce_q == 3'b000);
    proc_go = !proc_q && !ce_q[0];
    wr_req  = !gw_q || (!lwe_q && (lsel_q != '1));
    wr_mask = !gw_q ? '1 : (!lwe_q ? ~lsel_q : '0);
    op      = OP_IDLE;
    load    = 1'b0;
    step    = 1'b0;
    if (proc_go) begin
      if (sel_all) begin
        op   = OP_READ;
        load = 1'b1;
      end else begin
        op = OP_DESEL;
      end
    end else if (!ctrl_q) begin
      if (sel_all) begin
        op   = wr_req ? OP_WRITE : OP_READ;
        load = 1'b1;
      end else begin
        op = OP_DESEL;
      end
    end else if (busy_q) begin
      op   = wr_req ? OP_WRITE : OP_READ;
      step = !step_q;
    end
    busy_d = busy_q;
    if (load) busy_d = 1'b1;
    else if (op == OP_DESEL) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign ld_addr = addr_q;
  assign order   = order_q;
  assign wr_data = din_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              order,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, low;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = ld_addr;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
    low      = order ? (base_d[CNT_W-1:0] ^ cnt_d) : (base_d[CNT_W-1:0] + cnt_d);
    acc_addr = {base_d[ADDR_W-1:CNT_W], low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load || step) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we && mask[l]) cells[addr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/burst_sram_out.sv
module burst_sram_out
  import burst_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sram_op_e          op,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] q,
  output logic              oe
);
  logic oe_d, pend_q, pend_d;

  always_comb begin
    pend_d = (op == OP_DESEL);
    case (op)
      OP_READ:  oe_d = 1'b1;
      OP_WRITE: oe_d = 1'b0;
      default:  oe_d = pend_q ? 1'b0 : oe;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe     <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      oe     <= oe_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (op == OP_READ)  q <= rdata;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    step_n,
  input  logic                    order_sel,
  input  logic [2:0]              chip_en_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  sram_op_e          op;
  logic              load, step, order, arr_we;
  logic [ADDR_W-1:0] ld_addr, acc_addr;
  logic [LANES-1:0]  arr_mask;
  logic [DATA_W-1:0] wr_data, rd_data;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .step_n(step_n), .order_sel(order_sel), .chip_en_n(chip_en_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .din(din), .op(op), .load(load), .step(step), .ld_addr(ld_addr),
    .order(order), .wr_mask(arr_mask), .wr_data(wr_data)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W)) i_agen (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .order(order),
    .ld_addr(ld_addr), .acc_addr(acc_addr)
  );

  assign arr_we = (op == OP_WRITE);

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk(clk), .we(arr_we), .mask(arr_mask), .addr(acc_addr),
    .wdata(wr_data), .rdata(rd_data)
  );

  burst_sram_out #(.DATA_W(DATA_W)) i_out (
    .clk(clk), .rst_n(rst_n), .op(op), .rdata(rd_data),
    .q(dq_out), .oe(dq_oe)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             proc_strobe_n,
  input logic             ctrl_strobe_n,
  input logic [2:0]       chip_en_n,
  input logic             all_wr_n,
  input logic             lane_wr_en_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic             dq_oe,
  input logic             arr_we,
  input logic [LANES-1:0] arr_mask
);
  logic p_take, c_take, full_sel, wr_ctl, desel_in, no_start;

  always_comb begin
    full_sel = (chip_en_n == 3'b000);
    p_take   = !proc_strobe_n && !chip_en_n[0];
    c_take   = !p_take && !ctrl_strobe_n;
    wr_ctl   = !all_wr_n || (!lane_wr_en_n && (lane_sel_n != '1));
    desel_in = (p_take || c_take) && !full_sel;
    no_start = !p_take && ctrl_strobe_n;
  end

  // R2
  read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_take && full_sel) |=> ##1 dq_oe);

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_take && full_sel && wr_ctl) |=> ##1 !dq_oe);

  // R10
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_in |=> ##1 $stable(dq_oe));

  // R10
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel_in ##1 no_start |=> ##1 !dq_oe);

  // R8
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !$past(all_wr_n)) |-> (arr_mask == '1));

  // R7
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(all_wr_n)) |-> (arr_mask == ~$past(lane_sel_n)));
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) i_chk (
  .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
  .ctrl_strobe_n(ctrl_strobe_n), .chip_en_n(chip_en_n), .all_wr_n(all_wr_n),
  .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .dq_oe(dq_oe),
  .arr_we(arr_we), .arr_mask(arr_mask)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk, rst_n;
  logic [AW-1:0] addr_in;
  logic          proc_strobe_n, ctrl_strobe_n, step_n, order_sel;
  logic [2:0]    chip_en_n;
  logic          all_wr_n, lane_wr_en_n;
  logic [NL-1:0] lane_sel_n;
  logic [DW-1:0] din, dq_out;
  logic          dq_oe;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  logic [DW-1:0] refm [1<<AW];

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .step_n(step_n), .order_sel(order_sel),
    .chip_en_n(chip_en_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return {12'(s * 5 + 1), 12'(a), 12'(a * 3 ^ s)};
  endfunction

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] b, input bit ord, input int k);
    logic [1:0] lo;
    lo = ord ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; step_n = 1'b1;
    chip_en_n = 3'b000; all_wr_n = 1'b1; lane_wr_en_n = 1'b1;
    lane_sel_n = '1; din = '0;
  endtask

  task automatic wr_one(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic gw, input logic [NL-1:0] sel_n);
    @(negedge clk);
    idle();
    ctrl_strobe_n = 1'b0; addr_in = a; din = d;
    all_wr_n = gw; lane_wr_en_n = 1'b0; lane_sel_n = sel_n;
    for (int l = 0; l < NL; l++)
      if (!gw || !sel_n[l]) refm[a][l*LW +: LW] = d[l*LW +: LW];
    @(negedge clk);
    idle();
  endtask

  task automatic rd_one(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    idle();
    ctrl_strobe_n = 1'b0; addr_in = a;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk({tag, " oe"}, DW'(dq_oe), DW'(1));
    chk({tag, " data"}, dq_out, refm[a]);
  endtask

  task automatic rd_burst(input logic [AW-1:0] b, input bit ord, input string tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) chk(tag, dq_out, refm[beat(b, ord, i - 2)]);
      idle();
      order_sel = ord;
      if (i == 0) begin proc_strobe_n = 1'b0; addr_in = b; end
      else if (i < 4) step_n = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); order_sel = 1'b0; addr_in = '0;
    repeat (3) @(negedge clk);
    chk("R12 oe in reset", DW'(dq_oe), DW'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 oe after reset", DW'(dq_oe), DW'(0));
  endtask

  task automatic t_orders();
    for (int k = 0; k < 4; k++) wr_one(AW'(8 + k), pat(8 + k, 1), 1'b0, '1);
    rd_burst(AW'(9), 1'b0, "R5 linear");
    rd_burst(AW'(9), 1'b1, "R6 interleaved");
  endtask

  task automatic t_ctrl_burst_write();
    logic [AW-1:0] b;
    b = AW'(18);
    @(negedge clk);
    idle(); order_sel = 1'b1;
    ctrl_strobe_n = 1'b0; addr_in = b; all_wr_n = 1'b0; din = pat(b, 2);
    refm[b] = din;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      idle(); order_sel = 1'b1; step_n = 1'b0; all_wr_n = 1'b0;
      din = pat(beat(b, 1'b1, k), 2);
      refm[beat(b, 1'b1, k)] = din;
    end
    @(negedge clk);
    idle();
    for (int k = 0; k < 4; k++) rd_one(AW'(16 + k), "R3 ctrl burst write");
  endtask

  task automatic t_lanes();
    wr_one(AW'(30), pat(30, 3), 1'b0, '1);
    wr_one(AW'(30), {DW{1'b1}}, 1'b1, 4'b1010);
    rd_one(AW'(30), "R7 lane write");
    wr_one(AW'(31), pat(31, 3), 1'b0, '1);
    @(negedge clk);
    idle();
    ctrl_strobe_n = 1'b0; addr_in = AW'(31); din = pat(31, 9);
    all_wr_n = 1'b0; lane_wr_en_n = 1'b1; lane_sel_n = '1;
    refm[31] = din;
    @(negedge clk);
    idle();
    rd_one(AW'(31), "R8 global write");
  endtask

  task automatic t_step_hold();
    @(negedge clk); idle(); order_sel = 1'b0;
    proc_strobe_n = 1'b0; addr_in = AW'(8);
    @(negedge clk); idle();
    @(negedge clk); idle(); step_n = 1'b0;
    chk("R4 beat0", dq_out, refm[8]);
    @(negedge clk); idle();
    chk("R4 held beat", dq_out, refm[8]);
    @(negedge clk);
    chk("R4 stepped beat", dq_out, refm[9]);
  endtask

  task automatic t_proc_ignore();
    rd_one(AW'(10), "R2 setup");
    @(negedge clk); idle();
    proc_strobe_n = 1'b0; chip_en_n = 3'b001; addr_in = AW'(20);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R2 ignored strobe", dq_out, refm[10]);
  endtask

  task automatic t_chip_enable();
    @(negedge clk); idle();
    ctrl_strobe_n = 1'b0; chip_en_n = 3'b100; addr_in = AW'(11);
    all_wr_n = 1'b0; din = pat(11, 7);
    @(negedge clk); idle();
    rd_one(AW'(11), "R9 deselected write");
  endtask

  task automatic t_deselect();
    rd_one(AW'(12), "R10 setup");
    idle(); proc_strobe_n = 1'b0; chip_en_n = 3'b010; addr_in = AW'(13);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R10 oe one cycle later", DW'(dq_oe), DW'(1));
    @(negedge clk);
    chk("R10 oe two cycles later", DW'(dq_oe), DW'(0));
    proc_strobe_n = 1'b0; addr_in = AW'(12);
    @(negedge clk); idle();
    chk("R1 oe one cycle after strobe", DW'(dq_oe), DW'(0));
    @(negedge clk);
    chk("R1 oe two cycles after strobe", DW'(dq_oe), DW'(1));
    chk("R1 data two cycles after strobe", dq_out, refm[12]);
  endtask

  task automatic t_write_quiet();
    rd_one(AW'(9), "R11 setup");
    idle(); ctrl_strobe_n = 1'b0; addr_in = AW'(14);
    all_wr_n = 1'b0; din = pat(14, 4); refm[14] = din;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R11 oe after write", DW'(dq_oe), DW'(0));
  endtask

  initial begin
    t_reset();
    t_orders();
    t_ctrl_burst_write();
    t_lanes();
    t_step_hold();
    t_proc_ignore();
    t_chip_enable();
    t_deselect();
    t_write_quiet();
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule